// File: doc/BRIEF.md
# Pixel Block Input Framer

The framer sits at the front of a block-transform pipeline. It takes a stream of unsigned pixel samples and groups them into square blocks (8x8, so 64 samples, by default). A start strobe that arrives together with a sample marks that sample as element 0 of a new block. From then on the framer takes exactly one block's worth of samples, whatever their content, and then waits for a fresh strobe. While a block is being collected the strobe is ignored. A strobe held high makes blocks follow each other with no idle cycle.

Each accepted pixel is re-centred to signed form by subtracting half the pixel range. It is then presented downstream, one cycle later, with its raster index and a flag that marks index 0. A plain status output, `blk_rdy`, tells the source whether a new block can start. That is true only when the framer is idle and the downstream stage reports room for another whole block.

Back-pressure works at block granularity only. Once a block has started, every sample qualified by `in_valid` is taken. A low `in_valid` cycle pauses the count and does not abort the block. The output stream has no ready: the downstream stage guarantees space for a whole block through `dn_room` before the block starts. A strobe offered while `blk_rdy` is low is dropped along with its sample.

Top module: `pix_block_framer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `clr` is sampled high, `out_valid` is 0 and the framer is idle. In that state `blk_rdy` equals `dn_room`.
- R2: A sample with `in_valid`=1 and `in_start`=1, offered while idle with `dn_room`=1, appears on the next cycle with `out_valid`=1, `out_idx`=0 and `out_first`=1.
- R3: While idle, a sample offered without `in_start` is dropped and produces no `out_valid`.
- R4: Within a block the accepted samples carry `out_idx` 0,1,...,63 in arrival order. `out_first` is 1 only at index 0. Cycles with `in_valid`=0 take no index.
- R5: `in_start` offered during a block has no effect: the sample is taken with the next index and the block keeps its length.
- R6: After the 64th sample the framer returns to idle. Later samples without `in_start` are dropped.
- R7: With `in_start` and `in_valid` held high and `dn_room`=1, the sample right after index 63 is taken as index 0 of the next block, with no idle cycle.
- R8: `out_data` is the 9-bit two's-complement value of the accepted pixel minus 128 (range -128..127).
- R9: `blk_rdy` is 1 exactly when the framer is idle and `dn_room` is 1. It is 0 from the cycle after a block starts until the cycle after its last sample.
- R10: While idle with `dn_room`=0, a strobed sample is dropped and no block starts.
- R11: `clr` high during a block aborts it. The next block needs a new strobe and starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to idle |
| in_valid | input | 1 | Pixel sample present this cycle |
| in_start | input | 1 | Sample is element 0 of a new block |
| in_pix | input | 8 | Unsigned pixel |
| dn_room | input | 1 | Downstream can absorb a whole new block |
| blk_rdy | output | 1 | A new block may start now |
| out_valid | output | 1 | Shifted sample present |
| out_data | output | 9 | Pixel minus 128, signed |
| out_idx | output | 6 | Raster index within the block |
| out_first | output | 1 | High for index 0 only |

## Verification
The bench targets the boundary between blocks. A framer that stops one sample short or one sample late would misplace index 0 of the next block under a held strobe. Mid-block strobes are mixed in: a design that restarted on them would emit a second index 0 inside a block. Strobes are also offered while `dn_room` is low and samples arrive after a block ends, so a framer that started blocks without room, or kept counting after 63, would emit extra samples. A `clr` in the middle of a block checks that stale counts do not survive. Pixels at 0, 127, 128 and 255 expose a shift with the wrong sign or width.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_FILL = 1'b1
  } fr_state_e;
endpackage

// File: rtl/pfr_level_shift.sv
module pfr_level_shift #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W:0]   shifted
);
  // pix - 2**(PIX_W-1): invert the top bit and sign-extend it
  always_comb begin
    shifted = {~pix[PIX_W-1], ~pix[PIX_W-1], pix[PIX_W-2:0]};
  end
endmodule

// File: rtl/pfr_sample_ctr.sv
module pfr_sample_ctr #(
  parameter int BLK_N = 64,
  localparam int IDX_W = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_N - 1);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (take)   idx <= last ? '0 : idx + 1'b1;
  end

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (take && !last) |=> (idx == $past(idx) + 1'b1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (take && last) |=> (idx == '0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !take |=> $stable(idx));
endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_valid,
  input  logic in_start,
  input  logic dn_room,
  input  logic last,
  output logic take,
  output logic take_first,
  output logic blk_rdy
);
  fr_state_e state, state_nx;
  logic      idle;

  assign idle       = (state == FR_IDLE);
  assign blk_rdy    = idle && dn_room;
  assign take_first = !clr && in_valid && in_start && idle && dn_room;
  assign take       = take_first || (!clr && in_valid && !idle);

  always_comb begin
    state_nx = state;
    if (take_first)           state_nx = FR_FILL;
    else if (take && last)    state_nx = FR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= FR_IDLE;
    else if (clr) state <= FR_IDLE;
    else          state <= state_nx;
  end

  a_r6_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (state == FR_FILL && take && last) |=> blk_rdy == dn_room);
  a_r5_strobe_mid_block: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (state == FR_FILL && !(take && last)) |=> !blk_rdy);
  a_r10_no_room_stays: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (idle && !dn_room) |=> (state == FR_IDLE));
  a_r3_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (idle && !in_start) |-> !take);
endmodule

// File: rtl/pfr_out_stage.sv
module pfr_out_stage #(
  parameter int PIX_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [PIX_W-1:0] pix_raw,
  input  logic [PIX_W:0]   shifted,
  input  logic [IDX_W-1:0] idx,
  output logic             out_valid,
  output logic [PIX_W:0]   out_data,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_first
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
      out_first <= 1'b0;
    end else if (clr) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= take;
      out_first <= take && (idx == '0);
      if (take) begin
        out_data <= shifted;
        out_idx  <= idx;
      end
    end
  end

  a_r8_shift_value: assert property (@(posedge clk) disable iff (!rst_n || clr)
    take |=> ($signed(out_data) == $signed({1'b0, $past(pix_raw)}) - (2 ** (PIX_W - 1))));
  a_r2_first_flag: assert property (@(posedge clk) disable iff (!rst_n || clr)
    out_valid |-> (out_first == (out_idx == '0)));
  a_r1_quiet_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);
endmodule

// File: rtl/pix_block_framer.sv
module pix_block_framer #(
  parameter int PIX_W   = 8,
  parameter int BLK_DIM = 8,
  localparam int BLK_N  = BLK_DIM * BLK_DIM,
  localparam int IDX_W  = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             dn_room,
  output logic             blk_rdy,
  output logic             out_valid,
  output logic [PIX_W:0]   out_data,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_first
);
  logic             take, take_first, last;
  logic [IDX_W-1:0] idx;
  logic [PIX_W:0]   shifted;

  pfr_ctrl u_ctrl (
    .clk, .rst_n, .clr, .in_valid, .in_start, .dn_room, .last,
    .take, .take_first, .blk_rdy
  );

  pfr_sample_ctr #(.BLK_N(BLK_N)) u_ctr (
    .clk, .rst_n, .clr, .take, .idx, .last
  );

  pfr_level_shift #(.PIX_W(PIX_W)) u_shift (
    .pix(in_pix), .shifted
  );

  pfr_out_stage #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_out (
    .clk, .rst_n, .clr, .take, .pix_raw(in_pix), .shifted, .idx,
    .out_valid, .out_data, .out_idx, .out_first
  );

  a_r2_start_index_zero: assert property (@(posedge clk) disable iff (!rst_n || clr)
    take_first |=> (out_valid && out_first && out_idx == '0));
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (take_first && !last) |=> !blk_rdy);
endmodule

// File: tb/tb_pix_block_framer.sv
`timescale 1ns/1ps
module tb_pix_block_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_start = 1'b0;
  logic [7:0] in_pix = '0;
  logic       dn_room = 1'b1;
  logic       blk_rdy, out_valid, out_first;
  logic [8:0] out_data;
  logic [5:0] out_idx;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  // bench-side model of the framer requirements
  bit       m_fill = 0;
  int       m_cnt = 0;
  bit       e_valid = 0;
  int       e_data = 0;
  int       e_idx = 0;
  int       blocks_done = 0;

  always #2 clk = ~clk;

  pix_block_framer dut (
    .clk, .rst_n, .clr, .in_valid, .in_start, .in_pix, .dn_room,
    .blk_rdy, .out_valid, .out_data, .out_idx, .out_first
  );

  function automatic int shift_of(input logic [7:0] p);
    return int'(p) - 128;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  // one cycle: check last cycle's result, drive new inputs, update model
  task automatic step(input bit v, input bit s, input logic [7:0] p,
                      input bit room, input bit c);
    bit acc;
    @(negedge clk);
    chk("R3/R6 out_valid", int'(out_valid), int'(e_valid));
    if (e_valid && out_valid) begin
      chk("R4 out_idx", int'(out_idx), e_idx);
      chk("R2 out_first", int'(out_first), int'(e_idx == 0));
      chk("R8 out_data", int'($signed(out_data)), e_data);
    end
    in_valid = v; in_start = s; in_pix = p; dn_room = room; clr = c;
    #0.5;
    chk("R9 blk_rdy", int'(blk_rdy), int'(!m_fill && room));
    acc = !c && v && (m_fill || (s && room));
    e_valid = acc;
    if (acc) begin
      e_idx  = m_cnt;
      e_data = shift_of(p);
      if (m_cnt == 63) begin m_cnt = 0; m_fill = 0; blocks_done++; end
      else begin m_cnt++; m_fill = 1; end
    end
    if (c) begin m_fill = 0; m_cnt = 0; end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    #3;
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 blk_rdy in reset", int'(blk_rdy), 1);
    dn_room = 1'b0; #0.5;
    chk("R1 blk_rdy follows room", int'(blk_rdy), 0);
    dn_room = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // R3: samples without a strobe while idle
    phase = "R3";
    for (int i = 0; i < 5; i++) step(1, 0, 8'(i * 40), 1, 0);

    // R10: strobe with no downstream room
    phase = "R10";
    for (int i = 0; i < 3; i++) step(1, 1, 8'h55, 0, 0);

    // R2 R4 R8: one block with corner pixels and gaps
    phase = "R2/R4/R8";
    step(1, 1, 8'd0, 1, 0);
    for (int i = 1; i < 64; i++) begin
      logic [7:0] p;
      case (i % 4)
        0: p = 8'd127; 1: p = 8'd128; 2: p = 8'd255; default: p = 8'd1;
      endcase
      if (i % 9 == 0) step(0, 0, 8'hAA, 1, 0);
      step(1, 0, p, 1, 0);
    end

    // R6: samples after the block end are dropped
    phase = "R6";
    for (int i = 0; i < 4; i++) step(1, 0, 8'h33, 1, 0);

    // R5 R7: strobe held high through two blocks
    phase = "R5/R7";
    for (int i = 0; i < 128; i++) step(1, 1, 8'(i * 3), 1, 0);
    chk("R7 two back-to-back blocks", blocks_done, 3);

    // R11: clear mid-block, then restart
    phase = "R11";
    step(1, 1, 8'h10, 1, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 8'h20, 1, 0);
    step(1, 0, 8'h20, 1, 1);
    step(1, 0, 8'h21, 1, 0);
    step(1, 1, 8'h22, 1, 0);
    for (int i = 0; i < 63; i++) step(1, 0, 8'h23, 1, 0);
    chk("R11 block after clr completes", blocks_done, 4);

    // random mix
    phase = "random R2-R11 mix";
    for (int i = 0; i < 6000; i++) begin
      bit v, s, room, c;
      v    = ($urandom % 8) != 0;
      s    = ($urandom % 5) == 0;
      room = ($urandom % 6) != 0;
      c    = ($urandom % 300) == 0;
      step(v, s, 8'($urandom), room, c);
    end
    step(0, 0, 8'h00, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule